// File: doc/BRIEF.md
# Dual-Channel Polynomial Phase Combiner

This block turns two digitized phase readings into one phase error word whose target value is zero. The two readings come from phase digitizers that sit behind filters made with different resistor types. Their temperature coefficients therefore have opposite signs. Each reading is first trimmed for its own unit with an offset and a gain. The residual nonlinearity is then removed with a fixed polynomial of order ORDER (default 4) that belongs to that channel. Only after this correction are the two channels merged, as a weighted sum with programmable signed weights.

A single multiply-accumulate unit does all of the arithmetic. The steps run one after the other: the trim and the Horner steps of the first channel, the same for the second channel, then the two weighting products. A new sample is accepted only while the block is idle. A strobe that arrives during a computation is dropped and reported on a one-cycle overrun flag. Trims, coefficients and weights come from registers outside the block and are held steady while it runs.

All values are signed and DW bits wide (default 24). Gains, trimmed phases, coefficients and weights use FRAC fraction bits (default 20, so 1.0 is 1048576). Every multiply step computes clamp((A·B) >>> FRAC + C), where >>> is an arithmetic right shift that rounds toward minus infinity. The clamp limits the result to the range −8388608..8388607.

Top module: `dual_phase_combiner`

## Requirements
- R1: While rst_n is low, out_valid, busy and overrun are 0 and out_err is 0.
- R2: in_valid high at a rising edge while busy is low starts a computation and captures in_sp and in_n. busy is high from the next cycle for exactly 12 cycles. Changes on in_sp and in_n after the capture have no effect on the result.
- R3: Each channel is trimmed first as t = clamp(((x − off) · gain) >>> 20). The subtraction is exact at 25 bits, so an out-of-range difference is clamped only after the multiply.
- R4: Each channel is corrected next by Horner's method: acc = c4, then acc = clamp((acc · t) >>> 20 + ck) for k = 3, 2, 1, 0. Coefficient ck sits at bits [24k+23 : 24k] of that channel's coefficient port, and every step is clamped.
- R5: The result is e = clamp((wgt_n · p_n) >>> 20 + clamp((wgt_sp · p_sp) >>> 20)), where p_sp and p_n are the corrected values of the two channels.
- R6: out_valid is a single-cycle pulse. It rises at the 12th rising edge after the accepting edge, the same edge at which busy falls, and out_err carries the new result in that cycle.
- R7: in_valid high at an edge while busy is high is ignored: the running result is unchanged and no extra result appears. overrun is high for the one following cycle.
- R8: When the true weighted sum lies outside the 24-bit signed range, out_err is 8388607 for a positive sum and −8388608 for a negative sum.
- R9: out_err keeps the last result in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe for a new pair of phase words |
| in_sp | input | 24 | Phase word of the positive-tempco channel |
| in_n | input | 24 | Phase word of the negative-tempco channel |
| off_sp | input | 24 | Trim offset, positive-tempco channel |
| gain_sp | input | 24 | Trim gain, positive-tempco channel (Q.20) |
| off_n | input | 24 | Trim offset, negative-tempco channel |
| gain_n | input | 24 | Trim gain, negative-tempco channel (Q.20) |
| coef_sp | input | 120 | Polynomial coefficients c0..c4, positive-tempco channel |
| coef_n | input | 120 | Polynomial coefficients c0..c4, negative-tempco channel |
| wgt_sp | input | 24 | Combination weight of the positive-tempco channel (Q.20) |
| wgt_n | input | 24 | Combination weight of the negative-tempco channel (Q.20) |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_err | output | 24 | Combined phase error word |
| busy | output | 1 | A computation is in progress |
| overrun | output | 1 | One-cycle flag for a dropped input strobe |

## Verification
On every cycle the assertions check the control behaviour: acceptance only when idle, a step count that moves by one each cycle, out_valid lasting one cycle and landing where busy falls, overrun following a dropped strobe, captured inputs that stay stable, and an out_err that holds between results. The arithmetic itself can only be shown by the bench scenarios, which compare results with a model built from the formulas. These scenarios cover the trim, the Horner chain, the weighting, and clamping at both ends of the range. The same goes for the cycle count to the result, for data that changes during a run, and for results that must come out unchanged after an overrun.

// File: rtl/phc_pkg.sv
package phc_pkg;

   // Kind of work done by the shared multiply-accumulate in one step.
   typedef enum logic [1:0] {
      PHC_OP_TRIM    = 2'd0,
      PHC_OP_HORNER  = 2'd1,
      PHC_OP_WGT_SP  = 2'd2,
      PHC_OP_WGT_N   = 2'd3
   } phc_op_e;

   // Decoded control for one step of the schedule.
   typedef struct packed {
      phc_op_e op;
      logic    chan;        // 0: positive-tempco channel, 1: negative-tempco channel
      logic    first_mul;   // first Horner step, multiplicand is the top coefficient
      logic    last_mul;    // last Horner step of a channel, addend is c0
   } phc_ctl_t;

endpackage

// File: rtl/phc_mac.sv
// Shared multiply-accumulate: y = clamp((a*b) >>> FRAC + c) to DW signed bits.
module phc_mac #(
   parameter int DW            = 24,
   parameter int FRAC          = 20,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic signed [DW:0]   a,
   input  logic signed [DW-1:0] b,
   input  logic signed [DW-1:0] c,
   output logic signed [DW-1:0] y
);
   localparam int PW = 2*DW + 1;

   generate
      if (FRAC < 1 || FRAC >= DW) begin : g_bad_frac
         $error("phc_mac: FRAC must lie in 1..DW-1");
      end
   endgenerate

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;
   logic signed [PW-1:0] shifted;
   logic signed [PW:0]   sum;
   logic                 ovf_pos;
   logic                 ovf_neg;

   assign prod = a * b;

   generate
      if (ROUND_NEAREST) begin : g_round
         localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC-1);
         assign biased = prod + HALF;
      end else begin : g_floor
         assign biased = prod;
      end
   endgenerate

   assign shifted = biased >>> FRAC;
   assign sum     = $signed({shifted[PW-1], shifted})
                  + $signed({{(PW+1-DW){c[DW-1]}}, c});

   assign ovf_pos = !sum[PW] && (|sum[PW-1:DW-1]);
   assign ovf_neg =  sum[PW] && !(&sum[PW-1:DW-1]);

   always_comb begin
      if (ovf_pos)      y = {1'b0, {(DW-1){1'b1}}};
      else if (ovf_neg) y = {1'b1, {(DW-1){1'b0}}};
      else              y = sum[DW-1:0];
   end

endmodule

// File: rtl/phc_step_dec.sv
// Maps the step counter onto the operation schedule:
//   channel sp: trim, ORDER Horner steps; channel n: the same; then two weight steps.
module phc_step_dec
   import phc_pkg::*;
#(
   parameter int ORDER = 4,
   parameter int SW    = 4,
   parameter int CIW   = 3
) (
   input  logic [SW-1:0]  step,
   output phc_ctl_t       ctl,
   output logic [CIW-1:0] coef_idx
);
   localparam int SPC = ORDER + 1;

   int s;
   int loc;

   always_comb begin
      s            = int'(step);
      loc          = 0;
      ctl.op       = PHC_OP_TRIM;
      ctl.chan     = 1'b0;
      ctl.first_mul = 1'b0;
      ctl.last_mul = 1'b0;
      coef_idx     = '0;
      if (s < 2*SPC) begin
         if (s < SPC) begin
            loc      = s;
            ctl.chan = 1'b0;
         end else begin
            loc      = s - SPC;
            ctl.chan = 1'b1;
         end
         if (loc != 0) begin
            ctl.op        = PHC_OP_HORNER;
            ctl.first_mul = (loc == 1);
            ctl.last_mul  = (loc == ORDER);
            coef_idx      = CIW'(ORDER - loc);
         end
      end else if (s == 2*SPC) begin
         ctl.op = PHC_OP_WGT_SP;
      end else begin
         ctl.op   = PHC_OP_WGT_N;
         ctl.chan = 1'b1;
      end
   end

endmodule

// File: rtl/phc_seq.sv
// Step sequencer: accepts a sample when idle, walks NSTEP steps, flags overruns.
module phc_seq #(
   parameter int NSTEP = 12,
   parameter int SW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          accept,
   output logic          busy,
   output logic [SW-1:0] step,
   output logic          done,
   output logic          overrun
);
   localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

   generate
      if (NSTEP < 4 || (1 << SW) < NSTEP) begin : g_bad_seq
         $error("phc_seq: step counter too narrow for NSTEP");
      end
   endgenerate

   logic          busy_q;
   logic [SW-1:0] step_q;
   logic          done_q;
   logic          ovr_q;

   assign accept  = in_valid && !busy_q;
   assign busy    = busy_q;
   assign step    = step_q;
   assign done    = done_q;
   assign overrun = ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         done_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         done_q <= busy_q && (step_q == LAST);
         ovr_q  <= busy_q && in_valid;
         if (accept) begin
            busy_q <= 1'b1;
            step_q <= '0;
         end else if (busy_q) begin
            if (step_q == LAST) begin
               busy_q <= 1'b0;
               step_q <= '0;
            end else begin
               step_q <= step_q + SW'(1);
            end
         end
      end
   end

   // R2: an accepted strobe starts the schedule at step 0
   p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && step == '0));

   // R2: the schedule advances by exactly one step per cycle
   p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step != LAST) |=> (busy && step == SW'($past(step) + SW'(1))));

   // R6: completion is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: an overrun flag only follows a strobe seen while busy
   p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(busy && in_valid));

endmodule

// File: rtl/dual_phase_combiner.sv
// Two-channel trim + polynomial linearisation + weighted merge, one shared MAC.
module dual_phase_combiner
   import phc_pkg::*;
#(
   parameter int DW            = 24,
   parameter int FRAC          = 20,
   parameter int ORDER         = 4,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [DW-1:0]       in_sp,
   input  logic signed [DW-1:0]       in_n,
   input  logic signed [DW-1:0]       off_sp,
   input  logic signed [DW-1:0]       gain_sp,
   input  logic signed [DW-1:0]       off_n,
   input  logic signed [DW-1:0]       gain_n,
   input  logic [(ORDER+1)*DW-1:0]    coef_sp,
   input  logic [(ORDER+1)*DW-1:0]    coef_n,
   input  logic signed [DW-1:0]       wgt_sp,
   input  logic signed [DW-1:0]       wgt_n,
   output logic                       out_valid,
   output logic signed [DW-1:0]       out_err,
   output logic                       busy,
   output logic                       overrun
);
   localparam int NSTEP = 2*(ORDER + 1) + 2;
   localparam int SW    = $clog2(NSTEP);
   localparam int CIW   = (ORDER < 1) ? 1 : $clog2(ORDER + 1);

   generate
      if (ORDER < 1) begin : g_bad_order
         $error("dual_phase_combiner: ORDER must be at least 1");
      end
      if (DW < 4) begin : g_bad_dw
         $error("dual_phase_combiner: DW must be at least 4");
      end
   endgenerate

   // ---------------- coefficient unpacking ----------------
   logic signed [DW-1:0] c_sp [ORDER+1];
   logic signed [DW-1:0] c_n  [ORDER+1];

   generate
      for (genvar i = 0; i <= ORDER; i++) begin : g_unpack
         assign c_sp[i] = coef_sp[i*DW +: DW];
         assign c_n[i]  = coef_n[i*DW +: DW];
      end
   endgenerate

   // ---------------- sequencing ----------------
   logic          accept;
   logic [SW-1:0] step;
   logic          done;
   phc_ctl_t      ctl;
   logic [CIW-1:0] coef_idx;

   phc_seq #(.NSTEP(NSTEP), .SW(SW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .accept   (accept),
      .busy     (busy),
      .step     (step),
      .done     (done),
      .overrun  (overrun)
   );

   phc_step_dec #(.ORDER(ORDER), .SW(SW), .CIW(CIW)) u_dec (
      .step     (step),
      .ctl      (ctl),
      .coef_idx (coef_idx)
   );

   // ---------------- datapath state ----------------
   logic signed [DW-1:0] xs_q;     // captured phase, sp channel
   logic signed [DW-1:0] xn_q;     // captured phase, n channel
   logic signed [DW-1:0] xt_q;     // trimmed phase of the channel in progress
   logic signed [DW-1:0] acc_q;    // Horner accumulator
   logic signed [DW-1:0] part_q;   // p_sp, later the weighted sp term
   logic signed [DW-1:0] err_q;    // published result

   // ---------------- operand selection ----------------
   logic signed [DW:0]   op_a;
   logic signed [DW-1:0] op_b;
   logic signed [DW-1:0] op_c;
   logic signed [DW-1:0] mac_y;
   logic signed [DW-1:0] cur_coef;
   logic signed [DW-1:0] cur_top;

   assign cur_coef = ctl.chan ? c_n[coef_idx] : c_sp[coef_idx];
   assign cur_top  = ctl.chan ? c_n[ORDER]    : c_sp[ORDER];

   always_comb begin
      op_a = '0;
      op_b = '0;
      op_c = '0;
      unique case (ctl.op)
         PHC_OP_TRIM: begin
            if (ctl.chan) begin
               op_a = $signed({xn_q[DW-1], xn_q}) - $signed({off_n[DW-1], off_n});
               op_b = gain_n;
            end else begin
               op_a = $signed({xs_q[DW-1], xs_q}) - $signed({off_sp[DW-1], off_sp});
               op_b = gain_sp;
            end
         end
         PHC_OP_HORNER: begin
            op_a = ctl.first_mul ? {cur_top[DW-1], cur_top} : {acc_q[DW-1], acc_q};
            op_b = xt_q;
            op_c = cur_coef;
         end
         PHC_OP_WGT_SP: begin
            op_a = {wgt_sp[DW-1], wgt_sp};
            op_b = part_q;
         end
         PHC_OP_WGT_N: begin
            op_a = {wgt_n[DW-1], wgt_n};
            op_b = acc_q;
            op_c = part_q;
         end
         default: begin
            op_a = '0;
         end
      endcase
   end

   phc_mac #(.DW(DW), .FRAC(FRAC), .ROUND_NEAREST(ROUND_NEAREST)) u_mac (
      .a (op_a),
      .b (op_b),
      .c (op_c),
      .y (mac_y)
   );

   // ---------------- write-back ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xs_q   <= '0;
         xn_q   <= '0;
         xt_q   <= '0;
         acc_q  <= '0;
         part_q <= '0;
         err_q  <= '0;
      end else begin
         if (accept) begin
            xs_q <= in_sp;
            xn_q <= in_n;
         end
         if (busy) begin
            unique case (ctl.op)
               PHC_OP_TRIM:   xt_q <= mac_y;
               PHC_OP_HORNER: begin
                  acc_q <= mac_y;
                  if (!ctl.chan && ctl.last_mul) part_q <= mac_y;
               end
               PHC_OP_WGT_SP: part_q <= mac_y;
               PHC_OP_WGT_N:  err_q  <= mac_y;
               default: ;
            endcase
         end
      end
   end

   assign out_valid = done;
   assign out_err   = err_q;

   // R9: the published word only moves together with the valid strobe
   p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_err));

   // R6: a result appears exactly where the busy window closes
   p_valid_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!busy && $past(busy)));

   // R6: busy falling always delivers a result
   p_end_gives_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> out_valid);

   // R2: captured phase words stay fixed throughout a computation
   p_capture_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(xs_q) && $stable(xn_q)));

   // R4: Horner coefficient index never leaves the coefficient set
   p_coef_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl.op == PHC_OP_HORNER) |-> (int'(coef_idx) <= ORDER));

endmodule

// File: tb/dual_phase_combiner_bench.sv
module dual_phase_combiner_bench;

   localparam longint ONE  = 1048576;
   localparam longint SMAX = 8388607;
   localparam longint SMIN = -8388608;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [23:0] in_sp = '0;
   logic signed [23:0] in_n = '0;
   logic signed [23:0] off_sp = '0;
   logic signed [23:0] gain_sp = '0;
   logic signed [23:0] off_n = '0;
   logic signed [23:0] gain_n = '0;
   logic [119:0]       coef_sp = '0;
   logic [119:0]       coef_n = '0;
   logic signed [23:0] wgt_sp = '0;
   logic signed [23:0] wgt_n = '0;
   logic               out_valid;
   logic signed [23:0] out_err;
   logic               busy;
   logic               overrun;

   longint m_off_sp, m_gain_sp, m_off_n, m_gain_n, m_wsp, m_wn;
   longint m_csp [5];
   longint m_cn  [5];

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dual_phase_combiner u_dual_phase_combiner (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_sp(in_sp), .in_n(in_n),
      .off_sp(off_sp), .gain_sp(gain_sp), .off_n(off_n), .gain_n(gain_n),
      .coef_sp(coef_sp), .coef_n(coef_n),
      .wgt_sp(wgt_sp), .wgt_n(wgt_n),
      .out_valid(out_valid), .out_err(out_err), .busy(busy), .overrun(overrun)
   );

   // ---------------- reference model from the requirements ----------------
   function automatic longint sat24(longint v);
      if (v > SMAX) return SMAX;
      if (v < SMIN) return SMIN;
      return v;
   endfunction

   function automatic longint fmac(longint a, longint b, longint c);
      return sat24(((a * b) >>> 20) + c);
   endfunction

   function automatic longint chan_model(longint x, longint off, longint g, bit is_n);
      longint t, acc;
      t   = fmac(x - off, g, 0);                   // R3
      acc = is_n ? m_cn[4] : m_csp[4];
      for (int k = 3; k >= 0; k--)                  // R4
         acc = fmac(acc, t, is_n ? m_cn[k] : m_csp[k]);
      return acc;
   endfunction

   function automatic longint full_model(longint xs, longint xn);
      longint psp, pn;
      psp = chan_model(xs, m_off_sp, m_gain_sp, 1'b0);
      pn  = chan_model(xn, m_off_n,  m_gain_n,  1'b1);
      return fmac(m_wn, pn, fmac(m_wsp, psp, 0));   // R5
   endfunction

   // ---------------- helpers ----------------
   task automatic check(string req, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_regs();
      off_sp  = m_off_sp[23:0];
      gain_sp = m_gain_sp[23:0];
      off_n   = m_off_n[23:0];
      gain_n  = m_gain_n[23:0];
      wgt_sp  = m_wsp[23:0];
      wgt_n   = m_wn[23:0];
      for (int i = 0; i < 5; i++) begin
         coef_sp[i*24 +: 24] = m_csp[i][23:0];
         coef_n[i*24 +: 24]  = m_cn[i][23:0];
      end
   endtask

   task automatic set_identity(longint wsp, longint wn);
      m_off_sp = 0; m_gain_sp = ONE; m_off_n = 0; m_gain_n = ONE;
      m_wsp = wsp;  m_wn = wn;
      for (int i = 0; i < 5; i++) begin
         m_csp[i] = (i == 1) ? ONE : 0;
         m_cn[i]  = (i == 1) ? ONE : 0;
      end
      load_regs();
   endtask

   // Called at a falling edge. Checks busy window, latency, value and hold.
   task automatic run_case(string tag, longint xs, longint xn, bit probe_overrun);
      longint exp_v, held;
      int     lat;
      exp_v = full_model(xs, xn);
      in_sp = xs[23:0];
      in_n  = xn[23:0];
      in_valid = 1'b1;
      @(negedge clk);
      check({tag, " R2 busy after accept"}, longint'(busy), 1);
      if (probe_overrun) begin
         in_sp = ~in_sp;                 // R7: a second strobe with other data
         in_n  = in_n + 24'sd777;
      end else begin
         in_valid = 1'b0;
      end
      lat = 0;
      for (int n = 1; n <= 40; n++) begin
         @(negedge clk);
         if (n == 1) begin
            check({tag, " R7 overrun flag"}, longint'(overrun), probe_overrun ? 1 : 0);
            in_valid = 1'b0;
            in_sp = 24'sh35A5A5;         // R2: data changes during the run
            in_n  = -24'sh12345;
         end
         if (n == 2 && probe_overrun)
            check({tag, " R7 overrun one cycle"}, longint'(overrun), 0);
         if (n == 11)
            check({tag, " R2 busy still high"}, longint'(busy), 1);
         if (out_valid) begin
            lat = n;
            break;
         end
      end
      check({tag, " R6 latency"}, lat, 12);
      check({tag, " R6 busy low with valid"}, longint'(busy), 0);
      check({tag, " R3 R4 R5 result"}, longint'(out_err), exp_v);
      held = longint'(out_err);
      @(negedge clk);
      check({tag, " R6 single pulse"}, longint'(out_valid), 0);
      check({tag, " R9 result held"}, longint'(out_err), held);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      in_valid = 1'b1;                   // ignored during reset
      repeat (3) @(negedge clk);
      check("R1 out_valid", longint'(out_valid), 0);
      check("R1 busy", longint'(busy), 0);
      check("R1 overrun", longint'(overrun), 0);
      check("R1 out_err", longint'(out_err), 0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_identity();
      set_identity(ONE, 0);
      run_case("identity", 12345, -999, 1'b0);
      check("R5 identity passes sp", longint'(out_err), 12345);
      set_identity(0, ONE);
      run_case("identity_n", 4444, -76543, 1'b0);
      check("R5 identity passes n", longint'(out_err), -76543);
   endtask

   task automatic t_general();
      longint seed;
      longint xs, xn;
      m_off_sp = 5000;   m_gain_sp = 1153434;
      m_off_n  = -3000;  m_gain_n  = 943718;
      m_csp[0] = 100;    m_csp[1] = ONE + 20000; m_csp[2] = 30000;
      m_csp[3] = -15000; m_csp[4] = 4000;
      m_cn[0]  = -250;   m_cn[1]  = 1000000;     m_cn[2]  = -22000;
      m_cn[3]  = 9000;   m_cn[4]  = -1500;
      m_wsp = 629146;    m_wn = 419430;
      load_regs();
      seed = 7;
      for (int i = 0; i < 6; i++) begin
         seed = (seed * 1103515245 + 12345) & 64'h7fffffff;
         xs = (seed % 4000000) - 2000000;
         seed = (seed * 1103515245 + 12345) & 64'h7fffffff;
         xn = (seed % 4000000) - 2000000;
         run_case("general", xs, xn, 1'b0);
      end
      m_wn = -419430;                    // opposite-sign weight
      load_regs();
      run_case("neg_weight", 1500000, -1200000, 1'b0);
   endtask

   task automatic t_trim_clamp();
      set_identity(ONE, 0);
      m_off_sp = -8388608;               // R3: difference exceeds 24 bits
      load_regs();
      run_case("trim_clamp", 8388607, 0, 1'b0);
      check("R3 trim clamps high", longint'(out_err), SMAX);
   endtask

   task automatic t_overrun();
      set_identity(ONE, ONE);
      run_case("overrun", 100000, 200000, 1'b1);
      check("R7 result of first sample", longint'(out_err), 300000);
   endtask

   task automatic t_saturate();
      set_identity(SMAX, SMAX);
      run_case("sat_pos", 4000000, 4000000, 1'b0);
      check("R8 clamps positive", longint'(out_err), SMAX);
      run_case("sat_neg", -4000000, -4000000, 1'b0);
      check("R8 clamps negative", longint'(out_err), SMIN);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_identity();
      t_general();
      t_trim_clamp();
      t_overrun();
      t_saturate();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule